// File: doc/BRIEF.md
# Coin-Accumulating Dispense Controller

This block is a Moore state machine that keeps a running credit total for a coin-operated dispenser that sells one item at a price of 15 units. Two single-cycle, clock-synchronous strobes report coins: one for a 5-unit coin and one for a 10-unit coin. The machine has four credit levels: 0, 5, 10 and 15. When the credit reaches 15 it raises `open_o`, which releases one item.

No change is given. A coin that would take the total past the price leaves the machine at the full-price level, and any coin that arrives after that level is reached changes nothing. The full-price level, with `open_o` high, lasts until the synchronous active-low reset returns the machine to zero credit.

The credit level is held in a 2-bit register. The bit pattern equals the credit divided by 5. The next-state logic is written as a sum of products over those two bits and the two strobes. The two strobes are never active in the same cycle. That combination is a don't-care, and it still resolves to some defined state.

Top module: `coin_dispense_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the credit goes to 0 and `open_o` reads 0 after that edge.
- R2: Reset takes priority over a coin strobe presented in the same cycle: the credit after that edge is 0, not the credit plus the coin.
- R3: In a cycle with neither strobe active, the credit is unchanged.
- R4: A `nickel_i` pulse adds 5 to the credit when the credit is 0, 5 or 10.
- R5: A `dime_i` pulse adds 10 to the credit when the credit is 0 or 5.
- R6: `open_o` is 1 exactly when the credit is 15, and it depends only on the registered credit. It therefore rises one clock edge after the completing coin and never in the same cycle as that strobe.
- R7: A coin that would overshoot the price sets the credit to exactly 15. The case is a 10-unit coin arriving at a credit of 10.
- R8: Once the credit is 15, it stays at 15 and `open_o` stays 1 through idle cycles and further coins of either value, until reset.
- R9: The credit register encodes 0, 5, 10 and 15 units as 2'b00, 2'b01, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to zero credit |
| nickel_i | input | 1 | One-cycle strobe: a 5-unit coin was accepted |
| dime_i | input | 1 | One-cycle strobe: a 10-unit coin was accepted |
| open_o | output | 1 | Release one item; high while credit is 15 |

## Verification
The bound checker looks at the credit register on every cycle. It confirms that the register holds while idle, steps by one code for a 5-unit coin and by two codes for a 10-unit coin, saturates at the top code, and reads zero when reset ends. It also confirms that `open_o` follows the top code and rises only after a coin. Only the bench's scenarios show the whole story at the port. They sweep every three-symbol coin sequence (idle, 5-unit, 10-unit) of length four from reset, and compare `open_o` with a saturating sum. They also cover reset arriving together with a coin, the Moore timing of the release, and a long hold at full price.

// File: rtl/vend_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the coin-accumulating dispense controller.
// Assumes a fixed price of three 5-unit steps; credit code = credit / 5.
package vend_pkg;

    localparam int CREDIT_W = 2;

    // Credit levels; the bit pattern is the credit divided by 5 (R9).
    typedef enum logic [CREDIT_W-1:0] {
        CREDIT_0  = 2'b00,
        CREDIT_5  = 2'b01,
        CREDIT_10 = 2'b10,
        CREDIT_15 = 2'b11
    } credit_e;

endpackage

// File: rtl/credit_step.sv
`timescale 1ns/1ps
// Module: credit_step
// Combinational next-credit logic in sum-of-products form over the two
// credit bits and the two coin strobes.
// Assumes both strobes are never high together; that input is a don't-care
// but still maps to a defined code.
module credit_step
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_e nxt_o
);

    logic hi_q;
    logic lo_q;
    logic hi_d;
    logic lo_d;

    // Split the present credit code into its two bits.
    always_comb begin
        hi_q = cur_i[1];
        lo_q = cur_i[0];
    end

    // Upper bit: set at 10 or 15, by any dime, or by a nickel on an odd code.
    always_comb begin
        hi_d = hi_q | dime_i | (lo_q & nickel_i);
    end

    // Lower bit: flips on a nickel below 10; held high at or above 10 by any coin.
    always_comb begin
        lo_d = (nickel_i & ~lo_q) | (lo_q & ~nickel_i)
             | (hi_q & nickel_i) | (hi_q & dime_i);
    end

    // Reassemble the next credit code.
    always_comb begin
        nxt_o = credit_e'({hi_d, lo_d});
    end

endmodule

// File: rtl/credit_state_reg.sv
`timescale 1ns/1ps
// Module: credit_state_reg
// Holds the present credit code.
// Assumes a synchronous active-low reset that takes priority over the
// next-state input.
module credit_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e nxt_i,
    output credit_e cur_o
);

    // Register the next credit, or clear it to zero while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= CREDIT_0;
        end else begin
            cur_o <= nxt_i;
        end
    end

endmodule

// File: rtl/dispense_decode.sv
`timescale 1ns/1ps
// Module: dispense_decode
// Moore output decode: release is driven from the registered credit only.
// Assumes the full-price level is the code with both bits set.
module dispense_decode
    import vend_pkg::*;
(
    input  credit_e cur_i,
    output logic    open_o
);

    // Release when both credit bits are set (full price reached).
    always_comb begin
        open_o = cur_i[1] & cur_i[0];
    end

endmodule

// File: rtl/coin_dispense_ctrl.sv
`timescale 1ns/1ps
// Module: coin_dispense_ctrl (top)
// Accumulates 5- and 10-unit coins up to a price of 15, saturating without
// change, and holds the release output until reset.
// Assumes single-cycle clock-synchronous strobes that never overlap.
module coin_dispense_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);

    credit_e credit_q;
    credit_e credit_d;

    credit_step u_step (
        .cur_i    (credit_q),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .nxt_o    (credit_d)
    );

    credit_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (credit_d),
        .cur_o (credit_q)
    );

    dispense_decode u_dec (
        .cur_i  (credit_q),
        .open_o (open_o)
    );

endmodule

// File: rtl/coin_dispense_ctrl_chk.sv
`timescale 1ns/1ps
// Module: coin_dispense_ctrl_chk
// Property checker bound to the top; watches the credit register and ports.
// Assumes strobes never overlap; overlapping cycles are excluded.
module coin_dispense_ctrl_chk
    import vend_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    nickel,
    input logic    dime,
    input logic    open_o,
    input credit_e state
);

    // Coming out of reset, the credit is zero (R1, R2, R9).
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == CREDIT_0 && !open_o));

    // Idle cycles hold the credit (R3).
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel && !dime) |=> $stable(state));

    // A nickel below full price moves up one code (R4).
    assert_nickel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel && !dime && state != CREDIT_15) |=> (state == $past(state) + 2'd1));

    // A dime at 0 or 5 moves up two codes (R5).
    assert_dime_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dime && !nickel && !state[1]) |=> (state == $past(state) + 2'd2));

    // Release follows the full-price code (R6).
    assert_open_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CREDIT_15) |-> open_o);

    // Release only rises after a coin in the previous cycle (R6).
    assert_open_after_coin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(nickel || dime));

    // Overshooting dime at 10 lands on 15 (R7).
    assert_overshoot_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dime && !nickel && state == CREDIT_10) |=> (state == CREDIT_15));

    // Full price is held until reset (R8).
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CREDIT_15 && !(nickel && dime)) |=> (state == CREDIT_15 && open_o));

endmodule

bind coin_dispense_ctrl coin_dispense_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .nickel (nickel_i),
    .dime   (dime_i),
    .open_o (open_o),
    .state  (credit_q)
);

// File: tb/coin_dispense_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every four-step coin sequence from reset and compares the
// release output against a saturating credit sum, plus directed corners.
module coin_dispense_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic open_o;

    int checks = 0;
    int errors = 0;
    int credit = 0;
    bit done = 1'b0;

    coin_dispense_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .open_o   (open_o)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Compare the release output with its expected value.
    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: open_o=%0b expected %0b (credit model %0d)", tag, got, exp, credit);
        end
    endtask

    // Synchronous reset for one edge, optionally with a coin presented (R2).
    task automatic do_reset(input bit n, input bit d);
        rst_n = 1'b0;
        nickel_i = n;
        dime_i = d;
        @(negedge clk);
        rst_n = 1'b1;
        nickel_i = 1'b0;
        dime_i = 1'b0;
        credit = 0;
    endtask

    // Present one symbol (0 idle, 1 nickel, 2 dime) and check after the edge.
    task automatic coin(input int kind, input string tag);
        int add;
        nickel_i = (kind == 1);
        dime_i = (kind == 2);
        @(negedge clk);
        nickel_i = 1'b0;
        dime_i = 1'b0;
        add = (kind == 1) ? 5 : (kind == 2) ? 10 : 0;
        credit = (credit + add > 15) ? 15 : credit + add;
        chk(open_o, credit == 15, tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset(1'b0, 1'b0);
        chk(open_o, 1'b0, "R1 reset state");

        // Exhaustive sweep over all length-4 sequences of {idle, nickel, dime}.
        for (int seq = 0; seq < 81; seq++) begin
            int code;
            do_reset(1'b0, 1'b0);
            chk(open_o, 1'b0, "R1 after reset");
            code = seq;
            for (int k = 0; k < 4; k++) begin
                int sym;
                string tag;
                sym = code % 3;
                code = code / 3;
                if (credit == 15)                            tag = "R8 hold at full";
                else if (sym == 2 && credit == 10)           tag = "R7 overshoot";
                else if (sym == 0)                           tag = "R3 idle";
                else if (sym == 1)                           tag = "R4 nickel";
                else                                         tag = "R5 dime";
                coin(sym, {tag, " / R6 open"});
            end
        end

        // R2: reset at credit 10 with a nickel presented must clear, not reach 15.
        do_reset(1'b0, 1'b0);
        coin(2, "R5 setup");
        do_reset(1'b1, 1'b0);
        chk(open_o, 1'b0, "R2 reset beats nickel");
        coin(2, "R2 credit was zero");
        coin(1, "R2 credit was zero");

        // R2: reset at full price with a dime presented.
        do_reset(1'b0, 1'b1);
        chk(open_o, 1'b0, "R2 reset beats dime");

        // R6: release must not rise while the completing coin is still presented.
        coin(1, "R4 setup");
        nickel_i = 1'b0;
        dime_i = 1'b1;
        #1;
        chk(open_o, 1'b0, "R6 Moore timing");
        @(negedge clk);
        dime_i = 1'b0;
        credit = 15;
        chk(open_o, 1'b1, "R6 rises after edge");

        // R8: long hold at full price under mixed traffic.
        for (int k = 0; k < 24; k++) begin
            coin(k % 3, "R8 long hold");
        end
        do_reset(1'b0, 1'b0);
        chk(open_o, 1'b0, "R1 reset from full");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule